// File: doc/BRIEF.md
# Receive Front-End Source Select with DC Offset Removal

This block sits between two 14-bit converter sample streams (called A and B) and the in-phase and quadrature inputs of a down-converter. A small register file, written over a simple settings-bus write port, picks for each of the I and Q paths whether it carries stream A, stream B or a constant zero. Each path then removes a DC offset before the sample leaves the block.

The offset removal on each path has two modes, chosen per path by the top bit of that path's offset register. In fixed mode a programmed signed 14-bit value is subtracted. In tracking mode a per-path accumulator with fractional bits integrates the corrected output, and its integer part is subtracted. This forms a first-order high-pass loop that pulls a constant input towards zero. When a path leaves fixed mode, the tracking loop starts from the programmed value, so the output does not jump. Every subtraction clips to the signed 14-bit range.

Samples are taken on a strobe. The corrected I and Q words are registered, and a valid flag marks the cycle after each strobe.

Top module: `rxfe_iq_frontend`

## Requirements
- R1: After reset the selection register holds 0x4, so I carries stream A and Q carries stream B. Both paths start in tracking mode with a zero accumulator, and the first sample passes through unchanged. The outputs and the valid flag are zero.
- R2: Bits [1:0] of the selection register choose the I source: 00 is stream A, 01 is stream B, and 10 or 11 is constant zero.
- R3: Bits [3:2] of the selection register choose the Q source, using the same codes as R2.
- R4: The I offset register is at BASE_ADDR+3, the Q offset register at BASE_ADDR+4 and the selection register at BASE_ADDR+5. Writes to any other address change nothing.
- R5: When bit 31 of a path's offset register is 1, the output is the selected sample minus the sign-extended value in bits [13:0] of that register.
- R6: The result of every subtraction clips to the range -8192..8191 and never wraps.
- R7: When bit 31 is 0, the subtracted value is the accumulator shifted right by FRAC_W (a floor). On each strobe the accumulator gains the corrected output, weighted by 2^-DC_SHIFT. A constant input therefore decays over time.
- R8: When a path moves from fixed mode to tracking mode, its accumulator already holds the fixed value, so the first tracking output equals the last fixed-mode output for the same input.
- R9: The output words and the valid flag update at the clock edge after the strobe edge. The valid flag is high for exactly one cycle per strobe. Without a strobe the outputs and the tracking accumulators hold.
- R10: The I and Q paths have independent modes and offsets. Configuring one path leaves the other path's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Settings write enable |
| cfg_addr | input | ADDR_W | Settings word address |
| cfg_data | input | 32 | Settings write data |
| adc_a | input | ADC_W | Converter stream A sample, two's complement |
| adc_b | input | ADC_W | Converter stream B sample, two's complement |
| smp_stb | input | 1 | Sample strobe |
| i_out | output | ADC_W | Corrected in-phase sample |
| q_out | output | ADC_W | Corrected quadrature sample |
| out_vld | output | 1 | High for one cycle after each strobe |

## Verification
A settings write takes effect at the edge that captures it, so a sample strobed at any later edge sees the new configuration. A sample strobed at edge k produces i_out, q_out and out_vld at edge k; the bench raises the strobe at a falling edge and reads the results at the next falling edge, half a cycle after they update. The tracking-mode checks compare each output against an integer model of the accumulator that is stepped once per strobe. After idle cycles, the bench confirms that the outputs held and that the valid flag dropped.

// File: rtl/rxfe_pkg.sv
package rxfe_pkg;

  typedef enum logic [1:0] {
    SRC_A  = 2'b00,
    SRC_B  = 2'b01,
    SRC_Z0 = 2'b10,
    SRC_Z1 = 2'b11
  } src_sel_e;

  localparam int OFS_DC_I  = 3;
  localparam int OFS_DC_Q  = 4;
  localparam int OFS_SEL   = 5;
  localparam int MODE_BIT  = 31;
  localparam int NPATH     = 2;
  localparam logic [3:0] SEL_RST = 4'h4;

endpackage

// File: rtl/rxfe_cfg_regs.sv
module rxfe_cfg_regs
  import rxfe_pkg::*;
#(
  parameter int ADC_W     = 14,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [31:0]                  data,
  output logic [2*NPATH-1:0]           sel,
  output logic [NPATH-1:0]             fix_en,
  output logic [NPATH-1:0][ADC_W-1:0]  fix_val
);

  localparam logic [ADDR_W-1:0] A_DC_I = ADDR_W'(BASE_ADDR + OFS_DC_I);
  localparam logic [ADDR_W-1:0] A_DC_Q = ADDR_W'(BASE_ADDR + OFS_DC_Q);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(BASE_ADDR + OFS_SEL);

  logic unused_data;
  assign unused_data = ^data[MODE_BIT-1:ADC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= SEL_RST;
      fix_en  <= '0;
      fix_val <= '0;
    end else if (we) begin
      if (addr == A_DC_I) begin
        fix_en[0]  <= data[MODE_BIT];
        fix_val[0] <= data[ADC_W-1:0];
      end
      if (addr == A_DC_Q) begin
        fix_en[1]  <= data[MODE_BIT];
        fix_val[1] <= data[ADC_W-1:0];
      end
      if (addr == A_SEL) begin
        sel <= data[2*NPATH-1:0];
      end
    end
  end

endmodule

// File: rtl/rxfe_src_sel.sv
module rxfe_src_sel
  import rxfe_pkg::*;
#(
  parameter int ADC_W = 14
) (
  input  logic [1:0]       code,
  input  logic [ADC_W-1:0] a,
  input  logic [ADC_W-1:0] b,
  output logic [ADC_W-1:0] x
);

  always_comb begin
    unique case (src_sel_e'(code))
      SRC_A:   x = a;
      SRC_B:   x = b;
      default: x = '0;
    endcase
  end

endmodule

// File: rtl/rxfe_dc_path.sv
module rxfe_dc_path #(
  parameter int ADC_W    = 14,
  parameter int FRAC_W   = 10,
  parameter int DC_SHIFT = 10,
  parameter int ACC_W    = ADC_W + FRAC_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stb,
  input  logic [ADC_W-1:0]        x,
  input  logic                    fixed_en,
  input  logic [ADC_W-1:0]        fixed_val,
  output logic [ADC_W-1:0]        y,
  output logic signed [ACC_W-1:0] acc
);

  localparam int EXT_W = ACC_W + 1;
  localparam int PAD_A = ACC_W - ADC_W;
  localparam int LSH   = FRAC_W - DC_SHIFT;
  localparam logic signed [EXT_W-1:0] MAX_V = EXT_W'((1 << (ADC_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] MIN_V = -MAX_V - EXT_W'(1);

  logic signed [ACC_W-1:0] x_ext, fix_ext, est, sub_val, inc;
  logic signed [EXT_W-1:0] diff;
  logic        [ADC_W-1:0] y_c;

  always_comb begin
    x_ext   = {{PAD_A{x[ADC_W-1]}}, x};
    fix_ext = {{PAD_A{fixed_val[ADC_W-1]}}, fixed_val};
    est     = acc >>> FRAC_W;
    sub_val = fixed_en ? fix_ext : est;
    diff    = {x_ext[ACC_W-1], x_ext} - {sub_val[ACC_W-1], sub_val};
    if (diff > MAX_V)      y_c = MAX_V[ADC_W-1:0];
    else if (diff < MIN_V) y_c = MIN_V[ADC_W-1:0];
    else                   y_c = diff[ADC_W-1:0];
    inc = ACC_W'({{PAD_A{y_c[ADC_W-1]}}, y_c} <<< LSH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      y   <= '0;
    end else begin
      if (fixed_en)  acc <= fix_ext <<< FRAC_W;
      else if (stb)  acc <= acc + inc;
      if (stb)       y   <= y_c;
    end
  end

endmodule

// File: rtl/rxfe_iq_frontend.sv
module rxfe_iq_frontend
  import rxfe_pkg::*;
#(
  parameter int ADC_W     = 14,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 32,
  parameter int FRAC_W    = 10,
  parameter int DC_SHIFT  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_data,
  input  logic [ADC_W-1:0]  adc_a,
  input  logic [ADC_W-1:0]  adc_b,
  input  logic              smp_stb,
  output logic [ADC_W-1:0]  i_out,
  output logic [ADC_W-1:0]  q_out,
  output logic              out_vld
);

  localparam int ACC_W = ADC_W + FRAC_W + 2;

  logic [2*NPATH-1:0]          mux_sel;
  logic [NPATH-1:0]            fix_en;
  logic [NPATH-1:0][ADC_W-1:0] fix_val;
  logic [NPATH-1:0][ADC_W-1:0] path_x;
  logic [NPATH-1:0][ADC_W-1:0] path_y;
  logic signed [ACC_W-1:0]     acc_mon [NPATH];

  rxfe_cfg_regs #(
    .ADC_W(ADC_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .data(cfg_data),
    .sel(mux_sel), .fix_en(fix_en), .fix_val(fix_val)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    rxfe_src_sel #(.ADC_W(ADC_W)) u_sel (
      .code(mux_sel[2*p +: 2]), .a(adc_a), .b(adc_b), .x(path_x[p])
    );
    rxfe_dc_path #(
      .ADC_W(ADC_W), .FRAC_W(FRAC_W), .DC_SHIFT(DC_SHIFT), .ACC_W(ACC_W)
    ) u_dc (
      .clk(clk), .rst(rst), .stb(smp_stb), .x(path_x[p]),
      .fixed_en(fix_en[p]), .fixed_val(fix_val[p]),
      .y(path_y[p]), .acc(acc_mon[p])
    );
  end

  assign i_out = path_y[0];
  assign q_out = path_y[1];

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= smp_stb;
  end

endmodule

// File: rtl/rxfe_iq_frontend_chk.sv
module rxfe_iq_frontend_chk #(
  parameter int ADC_W = 14,
  parameter int ACC_W = 26
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   smp_stb,
  input logic                   out_vld,
  input logic [ADC_W-1:0]       i_out,
  input logic [ADC_W-1:0]       q_out,
  input logic [3:0]             mux_sel,
  input logic [1:0]             fix_en,
  input logic [1:0][ADC_W-1:0]  fix_val,
  input logic signed [ACC_W-1:0] acc_i,
  input logic signed [ACC_W-1:0] acc_q
);

  // R1
  reset_sel_chk: assert property (@(posedge clk) $past(rst) |-> (mux_sel == 4'h4));

  // R9
  vld_after_stb_chk: assert property (@(posedge clk) disable iff (rst) smp_stb |=> out_vld);

  // R9
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst) !smp_stb |=> !out_vld);

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> ($stable(i_out) && $stable(q_out)));

  // R7
  acc_i_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!smp_stb && !fix_en[0]) |=> $stable(acc_i));

  // R7
  acc_q_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!smp_stb && !fix_en[1]) |=> $stable(acc_q));

  // R2
  i_zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && mux_sel[1] && fix_en[0] && fix_val[0] == '0) |=> (i_out == '0));

  // R3
  q_zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && mux_sel[3] && fix_en[1] && fix_val[1] == '0) |=> (q_out == '0));

endmodule

bind rxfe_iq_frontend rxfe_iq_frontend_chk #(.ADC_W(ADC_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .smp_stb(smp_stb), .out_vld(out_vld),
  .i_out(i_out), .q_out(q_out), .mux_sel(mux_sel), .fix_en(fix_en),
  .fix_val(fix_val), .acc_i(acc_mon[0]), .acc_q(acc_mon[1])
);

// File: tb/rxfe_iq_frontend_tb.sv
`timescale 1ns/1ps
module rxfe_iq_frontend_tb;

  localparam int BASE = 32;
  localparam int W    = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic [31:0]   cfg_data = '0;
  logic [W-1:0]  adc_a = '0;
  logic [W-1:0]  adc_b = '0;
  logic          smp_stb = 1'b0;
  logic [W-1:0]  i_out, q_out;
  logic          out_vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rxfe_iq_frontend u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .adc_a(adc_a), .adc_b(adc_b), .smp_stb(smp_stb),
    .i_out(i_out), .q_out(q_out), .out_vld(out_vld)
  );

  // fields: sel[87:84] fix_i[83:70] fix_q[69:56] a[55:42] b[41:28] exp_i[27:14] exp_q[13:0]
  localparam logic [87:0] VEC [8] = '{
    {4'h4, 14'(0),     14'(0),     14'(100),   14'(-200),  14'(100),   14'(-200)},
    {4'h1, 14'(10),    14'(-5),    14'(300),   14'(50),    14'(40),    14'(305)},
    {4'h2, 14'(7),     14'(0),     14'(1234),  14'(9),     14'(-7),    14'(1234)},
    {4'hB, 14'(0),     14'(-3),    14'(55),    14'(66),    14'(0),     14'(3)},
    {4'h4, 14'(-100),  14'(0),     14'(8150),  14'(0),     14'(8191),  14'(0)},
    {4'h5, 14'(100),   14'(8191),  14'(0),     14'(-8150), 14'(-8192), 14'(-8192)},
    {4'h4, 14'(8191),  14'(-8192), 14'(8191),  14'(-8192), 14'(0),     14'(0)},
    {4'h1, 14'(-8192), 14'(1),     14'(0),     14'(8191),  14'(8191),  14'(-1)}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ofs, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'(BASE + ofs); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic smp(input int a, input int b);
    @(negedge clk);
    adc_a = W'(a); adc_b = W'(b); smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  function automatic logic [31:0] fixw(input logic [W-1:0] v);
    return {1'b1, 17'b0, v};
  endfunction

  function automatic int sv(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int acc;
    int est;
    int y;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 i_out reset", sv(i_out), 0);
    check("R1 q_out reset", sv(q_out), 0);
    check("R1 out_vld reset", int'(out_vld), 0);
    // R1: default routing and tracking with empty accumulator
    smp(500, -300);
    check("R1 I=A default", sv(i_out), 500);
    check("R1 Q=B default", sv(q_out), -300);
    check("R9 valid after strobe", int'(out_vld), 1);
    @(negedge clk);
    // R9: valid is a single pulse, outputs hold
    check("R9 valid drops", int'(out_vld), 0);
    check("R9 I holds", sv(i_out), 500);

    // R2 R3 R5 R6: table of select codes and fixed offsets
    for (int k = 0; k < 8; k++) begin
      logic [87:0] v;
      v = VEC[k];
      wr(5, {28'b0, v[87:84]});
      wr(3, fixw(v[83:70]));
      wr(4, fixw(v[69:56]));
      smp(sv(v[55:42]), sv(v[41:28]));
      check("R2 R5 R6 table I", sv(i_out), sv(v[27:14]));
      check("R3 R5 R6 table Q", sv(q_out), sv(v[13:0]));
    end

    // R4: writes at neighbouring addresses change nothing
    wr(5, 32'h4);
    wr(3, fixw(14'(0)));
    wr(4, fixw(14'(0)));
    wr(2, 32'h8000_000F);
    wr(6, 32'h8000_0105);
    smp(11, 22);
    check("R4 I unaffected", sv(i_out), 11);
    check("R4 Q unaffected", sv(q_out), 22);

    // R8: leaving fixed mode keeps the offset
    wr(4, fixw(14'(1000)));
    smp(0, 1000);
    check("R8 Q fixed", sv(q_out), 0);
    wr(4, 32'h0000_0000);
    smp(0, 1000);
    check("R8 Q first tracking", sv(q_out), 0);
    smp(0, 1500);
    check("R8 Q tracking step", sv(q_out), 500);
    check("R10 I untouched", sv(i_out), 0);

    // R7: tracking loop on I with a constant input; Q fixed at zero
    wr(4, fixw(14'(0)));
    wr(3, 32'h0000_0000);
    acc = 0;
    for (int n = 0; n < 2000; n++) begin
      est = acc >>> 10;
      y = 2048 - est;
      acc = acc + y;
      smp(2048, n % 50);
      check("R7 I tracking", sv(i_out), y);
      if (n % 100 == 0) check("R10 Q fixed while I tracks", sv(q_out), n % 50);
    end
    check("R7 decay below 600", int'(sv(i_out) < 600), 1);

    // R9: no strobe, outputs hold
    y = sv(i_out);
    repeat (5) @(negedge clk);
    check("R9 hold I idle", sv(i_out), y);
    check("R9 valid low idle", int'(out_vld), 0);
    // R7: accumulator did not move while idle
    smp(2048, 0);
    est = acc >>> 10;
    check("R7 no drift idle", sv(i_out), 2048 - est);

    finish_run();
  end

endmodule